// File: doc/BRIEF.md
# SPI configuration register port

This block is the slave end of a four-wire serial control port for a converter-style device. A host lowers chip select and shifts in a 16-bit instruction: a read/write flag and a 15-bit register address. One or more data bytes follow. The port then writes those bytes into a small register file, or returns the register contents. The serial pins are brought into the system clock domain through synchronizers. All decoding runs on the system clock, so SCLK must stay well below the system clock rate.

Two configuration registers govern the port. Address 0x0000 holds the interface setup: bit order, the direction the address moves in a multibyte transfer, and a self-clearing soft reset. Each of these controls has a mirrored copy in the low half of the byte, so either bit order can program it. Address 0x0001 holds a single-transfer mode and a self-clearing pulse that resets the data path. A run of scratch registers gives streaming transfers real storage to work on. After a soft reset, the port refuses writes for a boot wait. The length of that wait is a parameter. Every pin is a plain control or status signal; nothing at the edge of the block uses a data handshake.

Top module: `spi_cfg_port`

## Requirements
- R1: After rst_n is released, every register reads 0x00, and sdo, dp_reset and boot_busy are all 0.
- R2: The host drives a frame while cs_n is low. sdi is sampled on the SCLK rising edge. The first 16 bits form the instruction word {rw, addr[14:0]}, where rw = 1 means read. For a read, sdo changes after each SCLK falling edge, and the first data bit appears after the fall that follows the 16th instruction bit.
- R3: Register 0x0000 bit 6, or its mirror bit 1, selects LSB-first order. When it is 1, the instruction word and every data byte travel least significant bit first, so addr[0] goes first and rw goes last. The order is taken while cs_n is high, so a change takes effect from the next frame.
- R4: After each data byte of a frame, the address moves by one and wraps modulo 2^15. It increments when register 0x0000 bit 5 (mirror bit 2) is 1 and decrements when that bit is 0.
- R5: A write to 0x0000 sets each control if either the control bit or its mirror is 1. A read of 0x0000 returns {0, L, A, 0, 0, A, L, 0} (bit 7 down to bit 0), where L is LSB-first and A is ascend.
- R6: When register 0x0001 bit 7 is 1 at the start of a frame, only the first data byte is transferred. Later bits in that frame write nothing and drive sdo at 0.
- R7: Writing 1 to register 0x0001 bit 1 raises dp_reset for exactly one clock cycle. Register 0x0001 reads back as {S, 7'b0}, where S is bit 7.
- R8: Writing 0x0000 with bit 7 or bit 0 set clears every register to 0x00 and abandons the rest of the current frame. It also raises boot_busy for BOOT_CYCLES clock cycles.
- R9: While boot_busy is high, writes are ignored and reads still return register contents.
- R10: The SCR_NUM scratch registers at SCR_BASE onward can be written and read. Writes to any unsupported address are ignored, and reads of one return 0x00.
- R11: Raising cs_n ends any frame and resets the bit counter, so a partial frame leaves nothing behind. While cs_n is high, sdo is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial read data out of the port |
| dp_reset | output | 1 | One-cycle data path reset pulse |
| boot_busy | output | 1 | High during the post-soft-reset write hold-off |

## Verification
The bench builds the port with BOOT_CYCLES = 2000, SCR_BASE = 2 and SCR_NUM = 4. With that boot wait, a full serial frame fits inside the hold-off window. A rejected write and a read that still works can therefore be seen during the hold-off, and the window's end is reached quickly. The four scratch registers give streaming runs in both address directions. Address 0x0010 stands in for an unsupported location.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W     = 15;
  localparam int INSTR_BITS = ADDR_W + 1;
  localparam int BYTE_BITS  = 8;
  localparam int CNT_W      = $clog2(INSTR_BITS);
  localparam logic [ADDR_W-1:0] ADDR_IFCFG = '0;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 15'd1;
  typedef logic [BYTE_BITS-1:0] byte_t;
  typedef logic [ADDR_W-1:0]    addr_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
  import spi_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  cs_s,
  input  logic  sdi_s,
  input  logic  cfg_lsb,
  input  logic  cfg_asc,
  input  logic  cfg_single,
  input  logic  soft_rst,
  input  byte_t rd_data,
  output addr_t addr,
  output logic  wr_en,
  output byte_t wr_data,
  output logic  sdo
);
  logic                  sclk_q, rise, fall;
  logic                  in_data, rw_q, done, abort, load_pend;
  logic                  lsb_f, asc_f, single_f;
  logic [CNT_W-1:0]      cnt;
  logic [INSTR_BITS-1:0] sr, sr_next;
  byte_t                 tx;
  addr_t                 addr_q;
  logic                  instr_end, byte_end, live;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign live      = ~abort & ~done;
  assign sr_next   = lsb_f ? {sdi_s, sr[INSTR_BITS-1:1]} : {sr[INSTR_BITS-2:0], sdi_s};
  assign instr_end = rise && live && !in_data && cnt == CNT_W'(INSTR_BITS-1);
  assign byte_end  = rise && live && in_data && cnt == CNT_W'(BYTE_BITS-1);
  assign wr_en     = byte_end && !rw_q;
  assign wr_data   = lsb_f ? sr_next[INSTR_BITS-1 -: BYTE_BITS] : sr_next[BYTE_BITS-1:0];
  assign addr      = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; in_data <= 1'b0; rw_q <= 1'b0; done <= 1'b0; abort <= 1'b0;
      load_pend <= 1'b0; lsb_f <= 1'b0; asc_f <= 1'b0; single_f <= 1'b0;
      cnt <= '0; sr <= '0; tx <= '0; addr_q <= '0; sdo <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      if (cs_s) begin
        in_data <= 1'b0; done <= 1'b0; abort <= 1'b0; load_pend <= 1'b0;
        cnt <= '0; sr <= '0; sdo <= 1'b0;
        lsb_f <= cfg_lsb; asc_f <= cfg_asc; single_f <= cfg_single;
      end else begin
        if (soft_rst) abort <= 1'b1;
        load_pend <= 1'b0;
        if (load_pend) tx <= rd_data;
        if (rise && live) begin
          sr  <= sr_next;
          cnt <= cnt + CNT_W'(1);
          if (instr_end) begin
            in_data   <= 1'b1;
            cnt       <= '0;
            rw_q      <= sr_next[INSTR_BITS-1];
            addr_q    <= sr_next[ADDR_W-1:0];
            load_pend <= sr_next[INSTR_BITS-1];
          end
          if (byte_end) begin
            cnt       <= '0;
            addr_q    <= asc_f ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);
            done      <= single_f;
            load_pend <= rw_q && !single_f;
          end
        end
        if (fall) begin
          if (in_data && rw_q && live) begin
            sdo <= lsb_f ? tx[0] : tx[BYTE_BITS-1];
            tx  <= lsb_f ? {1'b0, tx[BYTE_BITS-1:1]} : {tx[BYTE_BITS-2:0], 1'b0};
          end else begin
            sdo <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int SCR_BASE    = 2,
  parameter int SCR_NUM     = 4,
  parameter int BOOT_CYCLES = 1000000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t addr,
  input  byte_t wr_data,
  output byte_t rd_data,
  output logic  cfg_lsb,
  output logic  cfg_asc,
  output logic  cfg_single,
  output logic  soft_rst,
  output logic  dp_reset,
  output logic  boot_busy
);
  localparam int    BW     = $clog2(BOOT_CYCLES + 1);
  localparam addr_t BASE_A = ADDR_W'(SCR_BASE);
  localparam addr_t LAST_A = ADDR_W'(SCR_BASE + SCR_NUM - 1);

  logic [BW-1:0] boot_cnt;
  logic          wr_acc, soft_req, in_scr;
  addr_t         off;
  byte_t         scr [SCR_NUM];

  assign boot_busy = boot_cnt != '0;
  assign wr_acc    = wr_en && !boot_busy;
  assign soft_req  = wr_acc && addr == ADDR_IFCFG && (wr_data[7] | wr_data[0]);
  assign in_scr    = addr >= BASE_A && addr <= LAST_A;
  assign off       = addr - BASE_A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lsb <= 1'b0; cfg_asc <= 1'b0; cfg_single <= 1'b0;
      soft_rst <= 1'b0; dp_reset <= 1'b0; boot_cnt <= '0;
    end else begin
      soft_rst <= soft_req;
      dp_reset <= wr_acc && addr == ADDR_MODE && wr_data[1];
      if (soft_req) begin
        cfg_lsb <= 1'b0; cfg_asc <= 1'b0; cfg_single <= 1'b0;
        boot_cnt <= BW'(BOOT_CYCLES);
      end else begin
        if (boot_busy) boot_cnt <= boot_cnt - BW'(1);
        if (wr_acc && addr == ADDR_IFCFG) begin
          cfg_lsb <= wr_data[6] | wr_data[1];
          cfg_asc <= wr_data[5] | wr_data[2];
        end
        if (wr_acc && addr == ADDR_MODE) cfg_single <= wr_data[7];
      end
    end
  end

  for (genvar i = 0; i < SCR_NUM; i++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  scr[i] <= '0;
      else if (soft_req)                           scr[i] <= '0;
      else if (wr_acc && in_scr && off == ADDR_W'(i)) scr[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_IFCFG)
      rd_data = {1'b0, cfg_lsb, cfg_asc, 2'b00, cfg_asc, cfg_lsb, 1'b0};
    else if (addr == ADDR_MODE)
      rd_data = {cfg_single, 7'b0};
    else
      for (int i = 0; i < SCR_NUM; i++)
        if (in_scr && off == ADDR_W'(i)) rd_data = scr[i];
  end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SCR_BASE    = 2,
  parameter int SCR_NUM     = 4,
  parameter int BOOT_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic dp_reset,
  output logic boot_busy
);
  logic  cs_s, sclk_s, sdi_s;
  logic  cfg_lsb, cfg_asc, cfg_single, soft_rst, wr_en;
  addr_t addr;
  byte_t rd_data, wr_data;

  spi_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q({cs_s, sclk_s, sdi_s})
  );

  spi_cfg_engine u_engine (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s), .sdi_s(sdi_s),
    .cfg_lsb(cfg_lsb), .cfg_asc(cfg_asc), .cfg_single(cfg_single),
    .soft_rst(soft_rst), .rd_data(rd_data), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .sdo(sdo)
  );

  spi_cfg_regs #(.SCR_BASE(SCR_BASE), .SCR_NUM(SCR_NUM), .BOOT_CYCLES(BOOT_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cfg_lsb(cfg_lsb), .cfg_asc(cfg_asc), .cfg_single(cfg_single),
    .soft_rst(soft_rst), .dp_reset(dp_reset), .boot_busy(boot_busy)
  );
endmodule

// File: rtl/spi_cfg_chk.sv
module spi_cfg_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sdo,
  input logic dp_reset,
  input logic boot_busy,
  input logic soft_rst,
  input logic cfg_lsb,
  input logic cfg_asc,
  input logic cfg_single
);
  p_dp_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset |=> !dp_reset);
  p_soft_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> boot_busy);
  p_soft_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!cfg_lsb && !cfg_asc && !cfg_single));
  p_busy_no_dp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_busy |=> !dp_reset);
  p_busy_no_soft_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_busy |=> !soft_rst);
  p_idle_sdo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo);
endmodule

bind spi_cfg_port spi_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdo(sdo), .dp_reset(dp_reset),
  .boot_busy(boot_busy), .soft_rst(soft_rst), .cfg_lsb(cfg_lsb),
  .cfg_asc(cfg_asc), .cfg_single(cfg_single)
);

// File: tb/spi_cfg_port_tb.sv
module spi_cfg_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, dp_reset, boot_busy;
  int   nvec = 0, nbad = 0, dp_cnt = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_cfg_port #(.SCR_BASE(2), .SCR_NUM(4), .BOOT_CYCLES(2000)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .dp_reset(dp_reset), .boot_busy(boot_busy)
  );

  always @(posedge clk) if (dp_reset) dp_cnt++;

  typedef struct packed { logic rw; logic [14:0] a; logic [7:0] d; } vec_t;
  localparam vec_t VEC [12] = '{
    '{1'b1, 15'h0000, 8'h00}, '{1'b1, 15'h0001, 8'h00},
    '{1'b0, 15'h0002, 8'hA5}, '{1'b1, 15'h0002, 8'hA5},
    '{1'b0, 15'h0005, 8'h3C}, '{1'b1, 15'h0005, 8'h3C},
    '{1'b0, 15'h0010, 8'h77}, '{1'b1, 15'h0010, 8'h00},
    '{1'b0, 15'h0001, 8'h7D}, '{1'b1, 15'h0001, 8'h00},
    '{1'b0, 15'h0003, 8'h00}, '{1'b1, 15'h0003, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    sdi = b;
    repeat (6) @(negedge clk);
    r = sdo;
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic lsb, input logic rw, input logic [14:0] a,
                       input int n, input logic [31:0] wd, output logic [31:0] rd);
    logic [15:0] w;
    logic r;
    w = {rw, a};
    rd = '0;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 16; i++) spi_bit(lsb ? w[i] : w[15-i], r);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        spi_bit(lsb ? wd[8*k+i] : wd[8*k+7-i], r);
        rd[8*k + (lsb ? i : 7-i)] = r;
      end
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr1(input logic lsb, input logic [14:0] a, input logic [7:0] d);
    logic [31:0] rd;
    frame(lsb, 1'b0, a, 1, {24'h0, d}, rd);
  endtask

  task automatic rd1(input logic lsb, input logic [14:0] a, output logic [7:0] d);
    logic [31:0] rd;
    frame(lsb, 1'b1, a, 1, 32'h0, rd);
    d = rd[7:0];
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] rd;
    int          dp0;
    logic        junk;
    repeat (5) @(negedge clk);
    check("R1 sdo", {31'b0, sdo}, 0);
    check("R1 dp_reset", {31'b0, dp_reset}, 0);
    check("R1 boot_busy", {31'b0, boot_busy}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset reads, R2 framing, R5/R7 reserved bits, R10 scratch and unsupported
    for (int v = 0; v < 12; v++) begin
      if (VEC[v].rw) begin
        rd1(1'b0, VEC[v].a, b);
        check($sformatf("R2 R10 vector %0d", v), {24'h0, b}, {24'h0, VEC[v].d});
      end else begin
        wr1(1'b0, VEC[v].a, VEC[v].d);
      end
    end
    check("R11 sdo idle", {31'b0, sdo}, 0);

    // R4 ascending stream, R5 readback with ascend set
    wr1(1'b0, 15'h0000, 8'h24);
    rd1(1'b0, 15'h0000, b);
    check("R5 ascend readback", {24'h0, b}, 32'h24);
    frame(1'b0, 1'b0, 15'h0002, 3, 32'h00332211, rd);
    frame(1'b0, 1'b1, 15'h0002, 3, 32'h0, rd);
    check("R4 ascending stream", rd, 32'h00332211);

    // R4 descending stream
    wr1(1'b0, 15'h0000, 8'h00);
    frame(1'b0, 1'b0, 15'h0005, 2, 32'h00005544, rd);
    rd1(1'b0, 15'h0004, b);
    check("R4 descending addr 4", {24'h0, b}, 32'h55);
    rd1(1'b0, 15'h0005, b);
    check("R4 descending addr 5", {24'h0, b}, 32'h44);

    // R5 mirror bit alone sets the control
    wr1(1'b0, 15'h0000, 8'h04);
    rd1(1'b0, 15'h0000, b);
    check("R5 mirror ascend", {24'h0, b}, 32'h24);

    // R3 LSB-first via mirror, takes effect next frame
    wr1(1'b0, 15'h0000, 8'h02);
    rd1(1'b1, 15'h0000, b);
    check("R3 lsb readback", {24'h0, b}, 32'h42);
    wr1(1'b1, 15'h0002, 8'h96);
    rd1(1'b1, 15'h0002, b);
    check("R3 lsb scratch", {24'h0, b}, 32'h96);
    wr1(1'b1, 15'h0000, 8'h00);
    rd1(1'b0, 15'h0002, b);
    check("R3 msb after lsb write", {24'h0, b}, 32'h96);

    // R11 partial frame leaves nothing behind
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 5; i++) spi_bit(1'b1, junk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    rd1(1'b0, 15'h0002, b);
    check("R11 after partial frame", {24'h0, b}, 32'h96);

    // R6 single instruction
    wr1(1'b0, 15'h0001, 8'h80);
    rd1(1'b0, 15'h0001, b);
    check("R7 mode readback", {24'h0, b}, 32'h80);
    frame(1'b0, 1'b0, 15'h0003, 2, 32'h0000BBAA, rd);
    rd1(1'b0, 15'h0003, b);
    check("R6 first byte written", {24'h0, b}, 32'hAA);
    rd1(1'b0, 15'h0002, b);
    check("R6 second byte ignored", {24'h0, b}, 32'h96);
    wr1(1'b0, 15'h0001, 8'h00);

    // R7 datapath pulse
    dp0 = dp_cnt;
    wr1(1'b0, 15'h0001, 8'h02);
    check("R7 dp pulse cycles", dp_cnt - dp0, 1);
    rd1(1'b0, 15'h0001, b);
    check("R7 self clear", {24'h0, b}, 32'h00);

    // R8 soft reset, abandoned frame, R9 hold-off
    wr1(1'b0, 15'h0000, 8'h24);
    frame(1'b0, 1'b0, 15'h0000, 2, 32'h00008081, rd);
    check("R8 boot_busy high", {31'b0, boot_busy}, 1);
    rd1(1'b0, 15'h0003, b);
    check("R8 R9 scratch cleared, read in busy", {24'h0, b}, 32'h00);
    rd1(1'b0, 15'h0001, b);
    check("R8 rest of frame abandoned", {24'h0, b}, 32'h00);
    rd1(1'b0, 15'h0000, b);
    check("R8 config cleared", {24'h0, b}, 32'h00);
    wr1(1'b0, 15'h0002, 8'h5A);
    repeat (2000) @(negedge clk);
    check("R8 boot_busy ends", {31'b0, boot_busy}, 0);
    rd1(1'b0, 15'h0002, b);
    check("R9 busy write ignored", {24'h0, b}, 32'h00);
    wr1(1'b0, 15'h0002, 8'h5A);
    rd1(1'b0, 15'h0002, b);
    check("R9 write after hold-off", {24'h0, b}, 32'h5A);

    summary();
  end
endmodule